// File: doc/BRIEF.md
# Countdown Timer with Timeout Interrupt

This block is a register-mapped down-counter. Software programs a 32-bit start value, picks a single-run or a repeating mode, and starts the counter by writing 1 to the run register. The counter then drops by one on every clock edge. Reaching zero is the only event the block knows. That event latches a sticky flag, and the flag drives an interrupt line when its mask bit allows it.

In single-run mode the counter parks at zero after the event. In repeating mode it reloads itself on the next edge. Writing 0 to the run register halts the counter and clears it. The sticky flag is cleared by writing 1 to it. The register bus is a flat word-indexed interface with a write strobe and a combinational read path.

Top module: `cdown_timer`

Register indices on `addr_i` are: 0 run, 1 mode, 2 start value, 3 counter (read-only), 4 mask, 5 flag. Each single-bit register lives in bit 0.

## Requirements
- R1: After reset, or with rst_ni low, the counter, run, mode, start value, mask and flag all read 0, and irq_o is 0.
- R2: A write of 1 (bit 0) to index 0 makes the counter read the start value on the following cycle. This holds even if the counter is already running.
- R3: While running and nonzero, the counter decreases by exactly one per clock.
- R4: The edge that takes the counter from 1 to 0 sets the flag (index 5, bit 0). In single-run mode (index 1 bit 0 = 0), the counter then stays at 0.
- R5: In repeating mode (index 1 bit 0 = 1), a running counter at 0 reloads the start value on the next edge, giving a period of start value + 1 cycles.
- R6: A write of 0 to index 0 stops the counter, forces it to 0 and raises no event, even in repeating mode.
- R7: A start value of 0 is treated as 1, so an event still occurs.
- R8: Writing 1 to index 5 clears the flag; writing 0 to it leaves the flag unchanged.
- R9: The flag is set whether or not the mask is set. irq_o equals flag AND mask (index 4 bit 0).
- R10: If an event and a flag-clear write fall in the same cycle, the flag ends up set.
- R11: Run, mode, start value and mask read back what was written. Writes to the counter index are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Masked timeout interrupt |

## Verification
Two functions can land on the same edge: the timeout setting the flag, and a software write that clears it. The bench provokes this by issuing the clear write in the exact cycle the counter reads 1. It then reads the flag back and expects it still set. A second collision is also exercised: a stop write in repeating mode while the counter sits at zero. There, the stop must beat the automatic reload, and the counter must read 0 afterwards.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int AW = 3;
  typedef enum logic [AW-1:0] {
    A_RUN  = 3'd0,
    A_MODE = 3'd1,
    A_LOAD = 3'd2,
    A_CNT  = 3'd3,
    A_MASK = 3'd4,
    A_FLAG = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          run_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          flag_i,
  output logic          start_o,
  output logic          stop_o,
  output logic          clr_o,
  output logic          periodic_o,
  output logic          mask_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] rdata_o
);
  logic wr_run, wr_mode, wr_load, wr_mask;

  assign wr_run  = we_i && (addr_i == A_RUN);
  assign wr_mode = we_i && (addr_i == A_MODE);
  assign wr_load = we_i && (addr_i == A_LOAD);
  assign wr_mask = we_i && (addr_i == A_MASK);

  assign start_o = wr_run &&  wdata_i[0];
  assign stop_o  = wr_run && !wdata_i[0];
  assign clr_o   = we_i && (addr_i == A_FLAG) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      periodic_o <= 1'b0;
      mask_o     <= 1'b0;
      load_o     <= '0;
    end else begin
      if (wr_mode) periodic_o <= wdata_i[0];
      if (wr_mask) mask_o     <= wdata_i[0];
      if (wr_load) load_o     <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_RUN:   rdata_o[0] = run_i;
      A_MODE:  rdata_o[0] = periodic_o;
      A_LOAD:  rdata_o    = load_o;
      A_CNT:   rdata_o    = cnt_i;
      A_MASK:  rdata_o[0] = mask_o;
      A_FLAG:  rdata_o[0] = flag_i;
      default: rdata_o    = '0;
    endcase
  end

  // R11: stored fields only move on their own write
  p_load_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_load |=> $stable(load_o));
endmodule

// File: rtl/cdt_core.sv
module cdt_core #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          periodic_i,
  input  logic [DW-1:0] load_i,
  output logic          run_o,
  output logic [DW-1:0] cnt_o,
  output logic          expire_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] load_eff;

  // zero start value behaves as one
  assign load_eff = (load_i == '0) ? ONE : load_i;
  assign expire_o = run_o && (cnt_o == ONE) && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      cnt_o <= '0;
    end else if (stop_i) begin
      run_o <= 1'b0;
      cnt_o <= '0;
    end else if (start_i) begin
      run_o <= 1'b1;
      cnt_o <= load_eff;
    end else if (run_o) begin
      if (cnt_o != '0) cnt_o <= cnt_o - ONE;
      else if (periodic_i) cnt_o <= load_eff;
    end
  end

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && (cnt_o > ONE) && !start_i && !stop_i |=> cnt_o == $past(cnt_o) - ONE);
  p_oneshot_park_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && (cnt_o == '0) && !periodic_i && !start_i && !stop_i |=> cnt_o == '0);
  p_stop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_o == '0) && !run_o);
  p_start_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_o != '0) && run_o);
  p_periodic_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && (cnt_o == '0) && periodic_i && !start_i && !stop_i |=> cnt_o != '0);
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (expire_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i)    flag_o <= 1'b0;
  end

  assign irq_o = flag_o && mask_i;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !expire_i |=> !flag_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && flag_o |=> flag_o);
  p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          start, stop, clr, periodic, mask, run, expire, flag;
  logic [DW-1:0] load, cnt;

  cdt_regs #(.DW(DW)) i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .run_i(run), .cnt_i(cnt), .flag_i(flag),
    .start_o(start), .stop_o(stop), .clr_o(clr),
    .periodic_o(periodic), .mask_o(mask), .load_o(load), .rdata_o
  );

  cdt_core #(.DW(DW)) i_core (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop),
    .periodic_i(periodic), .load_i(load),
    .run_o(run), .cnt_o(cnt), .expire_o(expire)
  );

  cdt_irq i_irq (
    .clk_i, .rst_ni, .expire_i(expire), .clr_i(clr), .mask_i(mask),
    .flag_o(flag), .irq_o
  );

  p_event_at_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> cnt == '0);
endmodule

// File: tb/test_cdown_timer.sv
module test_cdown_timer;
  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 43;
  // indices: 0 run, 1 mode, 2 start value, 3 counter, 4 mask, 5 flag
  localparam vec_t TBL [NV] = '{
    '{0,3'd3,0 ,1,0,0,1},   // R1 counter 0
    '{0,3'd5,0 ,1,0,0,1},   // R1 flag 0
    '{1,3'd2,3 ,0,0,0,0},
    '{0,3'd2,0 ,1,3,0,11},  // R11
    '{1,3'd4,1 ,0,0,0,0},
    '{1,3'd0,1 ,0,0,0,0},
    '{0,3'd3,0 ,1,3,0,2},   // R2
    '{0,3'd3,0 ,1,2,0,3},   // R3
    '{0,3'd3,0 ,1,1,0,3},   // R3
    '{0,3'd3,0 ,1,0,1,4},   // R4
    '{0,3'd5,0 ,1,1,1,4},   // R4
    '{0,3'd3,0 ,1,0,1,4},   // R4 parked
    '{1,3'd5,0 ,0,0,0,0},
    '{0,3'd5,0 ,1,1,1,8},   // R8 write 0 no effect
    '{1,3'd5,1 ,0,0,0,0},
    '{0,3'd5,0 ,1,0,0,8},   // R8 cleared
    '{1,3'd1,1 ,0,0,0,0},
    '{0,3'd1,0 ,1,1,0,11},  // R11
    '{0,3'd3,0 ,1,3,0,5},   // R5
    '{0,3'd3,0 ,1,2,0,5},
    '{0,3'd3,0 ,1,1,0,5},
    '{0,3'd3,0 ,1,0,1,5},
    '{0,3'd3,0 ,1,3,1,5},   // R5 reload
    '{1,3'd4,0 ,0,0,0,0},
    '{0,3'd5,0 ,1,1,0,9},   // R9 flag set, masked
    '{1,3'd0,0 ,0,0,0,0},
    '{0,3'd3,0 ,1,0,0,6},   // R6
    '{0,3'd0,0 ,1,0,0,11},  // R11
    '{1,3'd5,1 ,0,0,0,0},
    '{1,3'd3,55,0,0,0,0},
    '{0,3'd3,0 ,1,0,0,11},  // R11 counter write ignored
    '{0,3'd5,0 ,1,0,0,6},   // R6 no event
    '{1,3'd2,0 ,0,0,0,0},
    '{1,3'd0,1 ,0,0,0,0},
    '{0,3'd3,0 ,1,1,0,7},   // R7
    '{0,3'd5,0 ,1,1,0,7},   // R7
    '{0,3'd3,0 ,1,1,0,7},   // R7 periodic
    '{1,3'd0,0 ,0,0,0,0},
    '{1,3'd2,2 ,0,0,0,0},
    '{1,3'd0,1 ,0,0,0,0},
    '{0,3'd3,0 ,1,2,0,2},   // R2
    '{1,3'd5,1 ,0,0,0,0},   // clear at count 1
    '{0,3'd5,0 ,1,1,0,10}   // R10
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  cdown_timer i_cdown_timer (.*);

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input int req, input logic [31:0] exp);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      we_i = TBL[i].we; addr_i = TBL[i].addr; wdata_i = TBL[i].wdata;
      #1;
      if (TBL[i].chk) begin
        check(TBL[i].req, rdata_o, TBL[i].exp);
        check(TBL[i].req, {31'd0, irq_o}, {31'd0, TBL[i].irq});
      end
    end
    // R1: reset in the middle of a run
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 3'd4; wdata_i = 1;
    @(negedge clk_i);
    addr_i = 3'd2; wdata_i = 32'd100;
    @(negedge clk_i);
    addr_i = 3'd0; wdata_i = 1;
    @(negedge clk_i);
    we_i = 1'b0;
    rst_ni = 1'b0;
    #1 check(1, {31'd0, irq_o}, 32'd0);
    rd(3'd3, 1, 0);
    rd(3'd2, 1, 0);
    rd(3'd4, 1, 0);
    rd(3'd0, 1, 0);
    rd(3'd1, 1, 0);
    rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule